// File: doc/BRIEF.md
# Hash Job Control Registers

This block is the register-mapped front end of a block-based hash or keyed-hash accelerator. Software programs a mode word, an optional starting byte count and a job length over a small 32-bit register bus. Writing the length starts the job. While the job runs, the block asks a datapath for 64-byte input blocks, and it counts the bytes the datapath reports as processed. It raises a gated main interrupt, a separate partial-result interrupt and a one-cycle trigger for a context-input DMA.

The running byte count starts from a value that depends on the mode. A key-processing job starts from 64, which covers the key block. A job that starts from the algorithm constants starts from 0. A continued job keeps the count that software wrote. Each completed block moves 64 bytes from the remaining count to the processed count. A closing job may end with a short tail, which is taken in one final step. When the job finishes or is suspended, software reads both counts back to save the context.

Top module: `hash_job_ctrl`

## Requirements
- R1: A write to the count register (address 0) stores the written value with bits [5:0] forced to zero.
- R2: A write to the length register (address 1) while mode bit 0 (key processing) is set loads the count with 64, whatever was written before. This takes priority over mode bit 1.
- R3: A length write with mode bit 1 (use algorithm constants) set and mode bit 0 clear loads the count with 0.
- R4: A length write with mode bits 0 and 1 both clear keeps the count that software wrote earlier.
- R5: A length write with a nonzero value pulses dp_start for one cycle on the next cycle and sets the job running. While the job runs, dp_blk_req stays high as long as the remaining count is nonzero. A length write of zero starts nothing.
- R6: When mode bit 2 (close) is clear, the stored length has bits [5:0] forced to zero. When mode bit 2 is set, the length is stored as written.
- R7: Each dp_blk_done pulse during a running job subtracts 64 from the remaining length and adds 64 to the count. If the remaining length is below 64, the whole remainder is added to the count and the length becomes 0.
- R8: After done or suspend, reading address 1 returns the remaining byte count, and reading address 0 returns the initial count plus the bytes processed. dp_done and dp_suspend both stop the job.
- R9: A read of address 0 while mode bit 3 (advanced DMA) is set and status bit 1 is clear pulses ctx_dma_req for one cycle on the next cycle. In every other case ctx_dma_req stays low.
- R10: irq_main is high exactly when the global enable (address 5, bit 0) is 1 and some status bit is set together with its enable bit (address 3).
- R11: irq_part equals the global enable AND status bit 1. The enable register at address 3 has no effect on it.
- R12: The status register (address 4) records events: bit 0 is set by dp_done, bit 1 is set by dp_suspend, and bit 2 is set by a block completion. Writing 1 to a bit clears only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acts on address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| dp_blk_done | input | 1 | Datapath finished one input block |
| dp_done | input | 1 | Datapath finished the job |
| dp_suspend | input | 1 | Datapath suspended the job for a context switch |
| dp_start | output | 1 | One-cycle job start pulse |
| dp_blk_req | output | 1 | Request for the next input block |
| irq_main | output | 1 | Gated main interrupt |
| irq_part | output | 1 | Partial-result interrupt |
| ctx_dma_req | output | 1 | One-cycle context-input DMA trigger |

## Verification
The hardest case to reach is the context DMA trigger being held back by a pending partial result. To reach it, the stimulus runs a job, suspends it partway through, and reads the count in advanced DMA mode while status bit 1 is still set. It then clears that bit with a write-1 and reads the count again, which must now produce the pulse. A closing job with a short tail checks the final step that is not a multiple of 64. Suspend readback checks that the saved counts match what a reference model has accumulated cycle by cycle.

// File: rtl/hash_job_ctrl.sv
module hash_job_ctrl #(
  parameter int DW  = 32,
  parameter int AW  = 3,
  parameter int BLK = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dp_blk_done,
  input  logic          dp_done,
  input  logic          dp_suspend,
  output logic          dp_start,
  output logic          dp_blk_req,
  output logic          irq_main,
  output logic          irq_part,
  output logic          ctx_dma_req
);
  localparam int LSB = $clog2(BLK);

  localparam logic [AW-1:0] A_CNT  = AW'(0);
  localparam logic [AW-1:0] A_LEN  = AW'(1);
  localparam logic [AW-1:0] A_MODE = AW'(2);
  localparam logic [AW-1:0] A_IEN  = AW'(3);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_SYS  = AW'(5);

  logic [DW-1:0] cnt, len;
  logic [3:0]    mode_q;
  logic [2:0]    irq_en, stat;
  logic          sys_en, running, start_q, ctx_q;

  wire wr_cnt  = reg_wr && reg_addr == A_CNT;
  wire wr_len  = reg_wr && reg_addr == A_LEN;
  wire blk_ev  = running && dp_blk_done;
  wire tail    = len < DW'(BLK);
  wire [DW-1:0] len_in = mode_q[2] ? reg_wdata : {reg_wdata[DW-1:LSB], {LSB{1'b0}}};

  logic [2:0] stat_set, stat_clr;
  assign stat_set = {blk_ev, dp_suspend, dp_done};
  assign stat_clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[2:0] : 3'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      len     <= '0;
      mode_q  <= '0;
      irq_en  <= '0;
      stat    <= '0;
      sys_en  <= 1'b0;
      running <= 1'b0;
      start_q <= 1'b0;
      ctx_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      ctx_q   <= reg_rd && reg_addr == A_CNT && mode_q[3] && !stat[1];
      stat    <= (stat & ~stat_clr) | stat_set;

      if (blk_ev) begin
        if (tail) begin
          cnt <= cnt + len;
          len <= '0;
        end else begin
          cnt <= cnt + DW'(BLK);
          len <= len - DW'(BLK);
        end
      end
      if (dp_done || dp_suspend) running <= 1'b0;

      if (wr_cnt) cnt <= {reg_wdata[DW-1:LSB], {LSB{1'b0}}};
      if (wr_len) begin
        len     <= len_in;
        running <= len_in != '0;
        start_q <= len_in != '0;
        if (mode_q[0])      cnt <= DW'(BLK);
        else if (mode_q[1]) cnt <= '0;
      end
      if (reg_wr && reg_addr == A_MODE) mode_q <= reg_wdata[3:0];
      if (reg_wr && reg_addr == A_IEN)  irq_en <= reg_wdata[2:0];
      if (reg_wr && reg_addr == A_SYS)  sys_en <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CNT:   reg_rdata = cnt;
      A_LEN:   reg_rdata = len;
      A_MODE:  reg_rdata = DW'(mode_q);
      A_IEN:   reg_rdata = DW'(irq_en);
      A_STAT:  reg_rdata = DW'(stat);
      A_SYS:   reg_rdata = DW'(sys_en);
      default: reg_rdata = '0;
    endcase
  end

  assign dp_start    = start_q;
  assign dp_blk_req  = running && len != '0;
  assign irq_main    = sys_en && |(stat & irq_en);
  assign irq_part    = sys_en && stat[1];
  assign ctx_dma_req = ctx_q;
endmodule

// File: rtl/hash_job_ctrl_chk.sv
module hash_job_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        dp_blk_done,
  input logic        dp_start,
  input logic        irq_main,
  input logic        irq_part,
  input logic        ctx_dma_req,
  input logic        sys_en,
  input logic        running,
  input logic [3:0]  mode_q,
  input logic [31:0] cnt,
  input logic [31:0] len
);
  a_r1_count_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0) |=> cnt[5:0] == 6'd0);

  a_r2_key_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && mode_q[0]) |=> cnt == 32'd64);

  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[31:6] != 26'd0) |=> dp_start);

  a_r7_block_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && dp_blk_done && len >= 32'd64 && !(reg_wr && reg_addr == 3'd1))
      |=> len == $past(len) - 32'd64);

  a_r9_ctx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_dma_req |-> $past(reg_rd && reg_addr == 3'd0 && mode_q[3]));

  a_r10_main_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_main |-> sys_en);

  a_r11_part_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_part |-> sys_en);
endmodule

bind hash_job_ctrl hash_job_ctrl_chk chk_i (.*);

// File: tb/hash_job_ctrl_tb_top.sv
module hash_job_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic dp_blk_done = 1'b0, dp_done = 1'b0, dp_suspend = 1'b0;
  logic dp_start, dp_blk_req, irq_main, irq_part, ctx_dma_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hash_job_ctrl dut_i (.*);

  // behavioural reference model
  logic [31:0] m_cnt, m_len;
  logic [3:0]  m_mode;
  logic [2:0]  m_en, m_stat;
  logic        m_sys, m_run, m_start, m_ctx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_len = 0; m_mode = 0; m_en = 0; m_stat = 0;
      m_sys = 0; m_run = 0; m_start = 0; m_ctx = 0;
    end else begin
      logic [2:0] ns;
      m_start = 0;
      m_ctx = reg_rd && reg_addr == 0 && m_mode[3] && !m_stat[1];
      ns = m_stat;
      if (reg_wr && reg_addr == 4) ns = ns & ~reg_wdata[2:0];
      if (m_run && dp_blk_done) begin
        if (m_len >= 64) begin m_len = m_len - 64; m_cnt = m_cnt + 64; end
        else begin m_cnt = m_cnt + m_len; m_len = 0; end
        ns[2] = 1;
      end
      if (dp_done)    begin m_run = 0; ns[0] = 1; end
      if (dp_suspend) begin m_run = 0; ns[1] = 1; end
      m_stat = ns;
      if (reg_wr) begin
        case (reg_addr)
          0: m_cnt = reg_wdata & ~32'h3F;
          1: begin
            m_len = m_mode[2] ? reg_wdata : (reg_wdata & ~32'h3F);
            m_run = m_len != 0;
            m_start = m_run;
            if (m_mode[0]) m_cnt = 64;
            else if (m_mode[1]) m_cnt = 0;
          end
          2: m_mode = reg_wdata[3:0];
          3: m_en = reg_wdata[2:0];
          5: m_sys = reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5 dp_start", 32'(dp_start), 32'(m_start));
      chk("R5 dp_blk_req", 32'(dp_blk_req), 32'(m_run && m_len != 0));
      chk("R10 irq_main", 32'(irq_main), 32'(m_sys && |(m_stat & m_en)));
      chk("R11 irq_part", 32'(irq_part), 32'(m_sys && m_stat[1]));
      chk("R9 ctx_dma_req", 32'(ctx_dma_req), 32'(m_ctx));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    dp_blk_done = which == 0; dp_done = which == 1; dp_suspend = which == 2;
    @(negedge clk);
    dp_blk_done = 0; dp_done = 0; dp_suspend = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 0, "R1 reset count");
    rd(1, 0, "R8 reset length");
    rd(4, 0, "R12 reset status");

    wr(0, 32'h1FF);
    rd(0, 32'h1C0, "R1 low bits dropped");

    // continue job: keeps written count
    wr(2, 0); wr(0, 32'h80); wr(1, 192);
    rd(0, 32'h80, "R4 count kept");
    for (int i = 0; i < 3; i++) pulse(0);
    rd(1, 0, "R7 length consumed");
    pulse(1);
    rd(0, 32'h140, "R8 count after done");
    rd(4, 32'h5, "R12 done and block bits");

    // key processing, closing, short tail
    wr(4, 7);
    wr(2, 32'h7); wr(0, 32'h1000); wr(1, 100);
    rd(0, 64, "R2 key preload 64");
    pulse(0);
    rd(1, 36, "R7 after one block");
    rd(0, 128, "R7 count after one block");
    pulse(0);
    rd(1, 0, "R7 tail consumed");
    rd(0, 164, "R7 tail added");
    pulse(1);

    // constants, non-close masks length
    wr(2, 32'h2); wr(0, 32'h400); wr(1, 32'h47);
    rd(0, 0, "R3 constants clear count");
    rd(1, 64, "R6 length masked");
    pulse(0); pulse(1);

    // zero-length write starts nothing
    wr(1, 0);
    rd(1, 0, "R5 zero length");

    // suspend, interrupt gating, context DMA
    wr(4, 7);
    wr(2, 32'h8); wr(0, 32'h200); wr(1, 256);
    pulse(0); pulse(2);
    rd(1, 192, "R8 remaining after suspend");
    rd(4, 32'h6, "R12 suspend status");
    rd(0, 32'h240, "R9 read with partial pending, no pulse");
    wr(3, 0); wr(5, 1);
    @(negedge clk); chk("R11 part ignores enable reg", 32'(irq_part), 1);
    chk("R10 main masked", 32'(irq_main), 0);
    wr(3, 2);
    @(negedge clk); chk("R10 main enabled", 32'(irq_main), 1);
    wr(5, 0);
    @(negedge clk); chk("R11 part needs global", 32'(irq_part), 0);
    wr(5, 1);
    wr(4, 32'h2);
    rd(4, 32'h4, "R12 only bit1 cleared");
    rd(0, 32'h240, "R9 read triggers DMA");
    chk("R9 pulse seen", 32'(ctx_dma_req), 1);
    @(negedge clk); chk("R9 pulse one cycle", 32'(ctx_dma_req), 0);
    wr(2, 0);
    rd(0, 32'h240, "R9 no pulse without advanced mode");
    chk("R9 still low", 32'(ctx_dma_req), 0);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule